// File: doc/BRIEF.md
# Fully Associative Translation Cache with Lockdown

This block caches recent virtual-to-physical page translations. It has a configurable number of entries, 64 by default. Each entry holds a virtual page tag, a physical page base, a page size code, a domain number, access permission bits and cache/buffer bits. A lookup is registered. In the following cycle the registered virtual address is compared against every valid entry in parallel. The block then reports either a hit, with the translated physical address and the entry's attributes, or a miss.

After a miss, an external table walker supplies a refill. The refill is written into a victim entry chosen by a round-robin pointer. Software can write a lockdown word to change how victims are chosen. The word's base field protects all entries below that index, so the pointer runs only from the base up to the last entry and then wraps back to the base. While the word's preserve flag is set, the next refill goes to the index the word names, and that entry is marked as locked. Locked entries survive both flush-all and line invalidation.

Top module: `page_xlat_cache`

## Requirements
- R1: A lookup presented with `lk_valid` in cycle N produces `rsp_valid` in cycle N+1. In that cycle the address is compared against all valid entries at once, and `rsp_hit` is high if any entry covers the address.
- R2: A refill writes the translation into one entry. Any later lookup inside that page hits.
- R3: The size codes are 0 = 1 KB, 1 = 4 KB, 2 = 64 KB and 3 = 1 MB. Only the virtual address bits above the page size are compared. On a hit, `rsp_pa` takes those upper bits from the physical base and the remaining low bits from the virtual address.
- R4: On a hit, `rsp_dom`, `rsp_ap`, `rsp_cb` and `rsp_size` return the values stored by the refill.
- R5: After reset every entry is invalid, the lockdown base is 0, the preserve flag is clear and the pointer is 0. A lookup then misses, and `rsp_valid` is low while no lookup is pending.
- R6: Refills without preserve take victims in rising index order. After the last entry the pointer wraps to the lockdown base. From reset with base 0, the 65th refill replaces the first one.
- R7: Entries with an index below the lockdown base are never chosen as round-robin victims. If a lockdown write raises the base above the pointer, the pointer moves up to the base.
- R8: While the preserve flag is set, a refill is written to the lockdown victim index and that entry becomes locked. The round-robin pointer is not advanced.
- R9: `inv_all` clears every entry that is not locked. Locked entries, meaning those below the base or marked by preserve, stay valid.
- R10: `inv_line` clears only the unlocked entries whose page covers `inv_va`, using each entry's own size. Other entries, and locked matching entries, stay valid.
- R11: An invalidate issued in the same cycle as a lookup takes effect before the lookup is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup found a covering entry |
| rsp_pa | output | 32 | Translated physical address |
| rsp_size | output | 2 | Page size code of the hit entry |
| rsp_dom | output | 4 | Domain of the hit entry |
| rsp_ap | output | 2 | Access permission bits of the hit entry |
| rsp_cb | output | 2 | Cache/buffer bits of the hit entry |
| rf_valid | input | 1 | Refill write strobe |
| rf_va | input | 32 | Refill virtual page address |
| rf_pa | input | 32 | Refill physical page address |
| rf_size | input | 2 | Refill page size code |
| rf_dom | input | 4 | Refill domain |
| rf_ap | input | 2 | Refill access permission bits |
| rf_cb | input | 2 | Refill cache/buffer bits |
| inv_all | input | 1 | Invalidate every unlocked entry |
| inv_line | input | 1 | Invalidate unlocked entries covering inv_va |
| inv_va | input | 32 | Address for line invalidation |
| ld_wr | input | 1 | Lockdown word write strobe |
| ld_base | input | 6 | Lockdown base index |
| ld_victim | input | 6 | Preserve victim index |
| ld_preserve | input | 1 | Preserve flag |

## Verification
Lookups are tried with addresses inside and just outside pages of each of the four sizes. This shows whether the tag mask and the physical address merge use the right bit boundary for every size code. A long run of refills exercises the round-robin order: a full fill followed by one more refill separates a correct wrap from an early or late wrap. A second such run, with a raised lockdown base, shows that the wrap lands on the base and leaves the low entries intact. Flush-all and line invalidation are applied to mixes of locked and unlocked entries, some of them issued together with a lookup. This separates the survival of locked entries and the invalidate-first ordering from a design that ignores locks or compares against stale state.

// File: rtl/page_xlat_cache.sv
module page_xlat_cache #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int DOM_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_valid,
  input  logic [VA_W-1:0]              lk_va,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [VA_W-1:0]              rsp_pa,
  output logic [1:0]                   rsp_size,
  output logic [DOM_W-1:0]             rsp_dom,
  output logic [1:0]                   rsp_ap,
  output logic [1:0]                   rsp_cb,
  input  logic                         rf_valid,
  input  logic [VA_W-1:0]              rf_va,
  input  logic [VA_W-1:0]              rf_pa,
  input  logic [1:0]                   rf_size,
  input  logic [DOM_W-1:0]             rf_dom,
  input  logic [1:0]                   rf_ap,
  input  logic [1:0]                   rf_cb,
  input  logic                         inv_all,
  input  logic                         inv_line,
  input  logic [VA_W-1:0]              inv_va,
  input  logic                         ld_wr,
  input  logic [$clog2(ENTRIES)-1:0]   ld_base,
  input  logic [$clog2(ENTRIES)-1:0]   ld_victim,
  input  logic                         ld_preserve
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = VA_W - 10;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  function automatic logic [TW-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return {TW{1'b1}};
      2'd1:    return {TW{1'b1}} << 2;
      2'd2:    return {TW{1'b1}} << 6;
      default: return {TW{1'b1}} << 10;
    endcase
  endfunction

  logic [TW-1:0]    tag_q [ENTRIES];
  logic [TW-1:0]    pfn_q [ENTRIES];
  logic [1:0]       sz_q  [ENTRIES];
  logic [DOM_W-1:0] dom_q [ENTRIES];
  logic [1:0]       ap_q  [ENTRIES];
  logic [1:0]       cb_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q, pin_q, lock_v, lk_m, inv_m;

  logic [IW-1:0] rr_q, rr_nx, base_q, vict_q, wr_idx, sel;
  logic          keep_q, req_q;
  logic [VA_W-1:0] req_va_q;
  logic [TW-1:0]   sel_mask;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lock_v[g] = pin_q[g] | (IW'(g) < base_q);
    assign lk_m[g]   = vld_q[g] &
                       (((req_va_q[VA_W-1:10] ^ tag_q[g]) & size_mask(sz_q[g])) == '0);
    assign inv_m[g]  = vld_q[g] &
                       (((inv_va[VA_W-1:10] ^ tag_q[g]) & size_mask(sz_q[g])) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_m[i]) sel = IW'(i);
  end

  assign sel_mask  = size_mask(sz_q[sel]);
  assign rsp_valid = req_q;
  assign rsp_hit   = req_q & (|lk_m);
  assign rsp_pa    = {(pfn_q[sel] & sel_mask) | (req_va_q[VA_W-1:10] & ~sel_mask),
                      req_va_q[9:0]};
  assign rsp_size  = sz_q[sel];
  assign rsp_dom   = dom_q[sel];
  assign rsp_ap    = ap_q[sel];
  assign rsp_cb    = cb_q[sel];

  assign wr_idx = keep_q ? vict_q : rr_q;

  always_comb begin
    rr_nx = rr_q;
    if (rf_valid && !keep_q)
      rr_nx = (rr_q == LAST) ? base_q : rr_q + 1'b1;
    if (ld_wr && rr_nx < ld_base)
      rr_nx = ld_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      req_va_q <= '0;
      rr_q     <= '0;
      base_q   <= '0;
      vict_q   <= '0;
      keep_q   <= 1'b0;
      vld_q    <= '0;
      pin_q    <= '0;
    end else begin
      req_q    <= lk_valid;
      req_va_q <= lk_va;
      rr_q     <= rr_nx;
      if (ld_wr) begin
        base_q <= ld_base;
        vict_q <= ld_victim;
        keep_q <= ld_preserve;
      end
      if (inv_all)       vld_q <= vld_q & lock_v;
      else if (inv_line) vld_q <= vld_q & ~(inv_m & ~lock_v);
      if (rf_valid) begin
        vld_q[wr_idx] <= 1'b1;
        pin_q[wr_idx] <= keep_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rf_valid) begin
      tag_q[wr_idx] <= rf_va[VA_W-1:10];
      pfn_q[wr_idx] <= rf_pa[VA_W-1:10];
      sz_q[wr_idx]  <= rf_size;
      dom_q[wr_idx] <= rf_dom;
      ap_q[wr_idx]  <= rf_ap;
      cb_q[wr_idx]  <= rf_cb;
    end
  end

  a_r2_refill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> vld_q[$past(wr_idx)]);

  a_r7_ptr_window: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q >= base_q);

  a_r8_preserve_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && keep_q |=> pin_q[$past(vict_q)]);

  a_r9_flush_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !rf_valid && !ld_wr |=> (vld_q & ~lock_v) == '0);

  a_r9_flush_keeps_locked: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !rf_valid && !ld_wr |=> (vld_q & lock_v) == $past(vld_q & lock_v));

  a_r10_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    inv_line && !inv_all && !rf_valid |=> (vld_q & $past(inv_m & ~lock_v)) == '0);
endmodule

// File: tb/page_xlat_cache_tb.sv
module page_xlat_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_size, rsp_ap, rsp_cb;
  logic [3:0] rsp_dom;
  logic rf_valid = 1'b0;
  logic [31:0] rf_va = '0, rf_pa = '0;
  logic [1:0] rf_size = '0, rf_ap = '0, rf_cb = '0;
  logic [3:0] rf_dom = '0;
  logic inv_all = 1'b0, inv_line = 1'b0;
  logic [31:0] inv_va = '0;
  logic ld_wr = 1'b0, ld_preserve = 1'b0;
  logic [5:0] ld_base = '0, ld_victim = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  page_xlat_cache dut_i (
    .clk, .rst_n, .lk_valid, .lk_va, .rsp_valid, .rsp_hit, .rsp_pa, .rsp_size,
    .rsp_dom, .rsp_ap, .rsp_cb, .rf_valid, .rf_va, .rf_pa, .rf_size, .rf_dom,
    .rf_ap, .rf_cb, .inv_all, .inv_line, .inv_va, .ld_wr, .ld_base, .ld_victim,
    .ld_preserve);

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic [1:0]  cb;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic [3:0] dom, input logic [1:0] ap, input logic [1:0] cb);
    rf_valid = 1'b1; rf_va = va; rf_pa = pa; rf_size = sz; rf_dom = dom; rf_ap = ap; rf_cb = cb;
    tick();
    rf_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic hit, input logic [31:0] pa,
                      input logic [3:0] dom, input logic [1:0] ap, input logic [1:0] cb,
                      input string req);
    exp_t e;
    e.hit = hit; e.pa = pa; e.dom = dom; e.ap = ap; e.cb = cb; e.req = req;
    sb_q.push_back(e);
    lk_valid = 1'b1; lk_va = va;
    tick();
    lk_valid = 1'b0;
  endtask

  task automatic miss(input logic [31:0] va, input string req);
    look(va, 1'b0, '0, '0, '0, '0, req);
  endtask

  task automatic lockdown(input logic [5:0] base, input logic [5:0] vic, input logic pres);
    ld_wr = 1'b1; ld_base = base; ld_victim = vic; ld_preserve = pres;
    tick();
    ld_wr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected response", 32'(rsp_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_hit === e.hit, {e.req, " hit"}, 32'(rsp_hit), 32'(e.hit));
        if (e.hit) begin
          chk(rsp_pa === e.pa, {e.req, " pa"}, rsp_pa, e.pa);
          chk(rsp_dom === e.dom, {e.req, " R4 dom"}, 32'(rsp_dom), 32'(e.dom));
          chk(rsp_ap === e.ap, {e.req, " R4 ap"}, 32'(rsp_ap), 32'(e.ap));
          chk(rsp_cb === e.cb, {e.req, " R4 cb"}, 32'(rsp_cb), 32'(e.cb));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R5 idle after reset", {30'd0, rsp_valid, rsp_hit}, 32'd0);
    tick();
    miss(32'h0040_3ABC, "R5 empty");

    refill(32'h0040_3000, 32'h0800_5000, 2'd1, 4'd3, 2'd2, 2'd1);
    look(32'h0040_3ABC, 1'b1, 32'h0800_5ABC, 4'd3, 2'd2, 2'd1, "R2 R1 4KB");
    miss(32'h0040_4000, "R3 4KB edge");
    refill(32'h1230_0000, 32'h4560_0000, 2'd3, 4'd5, 2'd1, 2'd3);
    look(32'h123A_BCDE, 1'b1, 32'h456A_BCDE, 4'd5, 2'd1, 2'd3, "R3 1MB");
    miss(32'h1240_0000, "R3 1MB edge");
    refill(32'h00A1_0000, 32'h00B2_0000, 2'd2, 4'd7, 2'd3, 2'd0);
    look(32'h00A1_F00F, 1'b1, 32'h00B2_F00F, 4'd7, 2'd3, 2'd0, "R3 64KB");
    miss(32'h00A2_0000, "R3 64KB edge");
    refill(32'h0000_0400, 32'h3000_0800, 2'd0, 4'd1, 2'd1, 2'd2);
    look(32'h0000_07FF, 1'b1, 32'h3000_0BFF, 4'd1, 2'd1, 2'd2, "R3 1KB");
    miss(32'h0000_0800, "R3 1KB edge");

    for (int i = 0; i < 60; i++)
      refill(32'h2000_0000 + (i << 12), 32'h4000_0000 + (i << 12), 2'd1, 4'd0, 2'd0, 2'd0);
    refill(32'h2100_0000, 32'h5100_0000, 2'd1, 4'd2, 2'd2, 2'd2);
    miss(32'h0040_3ABC, "R6 65th refill evicts first");
    look(32'h123A_BCDE, 1'b1, 32'h456A_BCDE, 4'd5, 2'd1, 2'd3, "R6 second kept");
    look(32'h2100_0010, 1'b1, 32'h5100_0010, 4'd2, 2'd2, 2'd2, "R6 new entry");
    look(32'h2003_B004, 1'b1, 32'h4003_B004, 4'd0, 2'd0, 2'd0, "R6 last entry");

    inv_all = 1'b1; tick(); inv_all = 1'b0;
    miss(32'h2100_0010, "R9 flush unlocked");
    miss(32'h123A_BCDE, "R9 flush 1MB");

    lockdown(6'd0, 6'd0, 1'b1);
    refill(32'h5000_0000, 32'h6000_0000, 2'd1, 4'd9, 2'd1, 2'd1);
    lockdown(6'd0, 6'd1, 1'b1);
    refill(32'h5000_1000, 32'h6000_1000, 2'd1, 4'd9, 2'd1, 2'd1);
    lockdown(6'd2, 6'd0, 1'b0);
    for (int i = 0; i < 62; i++)
      refill(32'h7000_0000 + (i << 12), 32'h7800_0000 + (i << 12), 2'd1, 4'd4, 2'd0, 2'd1);
    refill(32'h7100_0000, 32'h7900_0000, 2'd1, 4'd6, 2'd3, 2'd3);
    look(32'h5000_0020, 1'b1, 32'h6000_0020, 4'd9, 2'd1, 2'd1, "R7 R8 locked A");
    look(32'h5000_1020, 1'b1, 32'h6000_1020, 4'd9, 2'd1, 2'd1, "R7 R8 locked B");
    miss(32'h7000_0000, "R6 wrap to base");
    look(32'h7000_1008, 1'b1, 32'h7800_1008, 4'd4, 2'd0, 2'd1, "R6 next kept");
    look(32'h7100_0008, 1'b1, 32'h7900_0008, 4'd6, 2'd3, 2'd3, "R6 wrapped entry");

    inv_all = 1'b1; tick(); inv_all = 1'b0;
    look(32'h5000_0020, 1'b1, 32'h6000_0020, 4'd9, 2'd1, 2'd1, "R9 locked survives");
    look(32'h5000_1020, 1'b1, 32'h6000_1020, 4'd9, 2'd1, 2'd1, "R9 locked survives B");
    miss(32'h7000_1008, "R9 unlocked gone");
    miss(32'h7100_0008, "R9 unlocked gone 2");

    refill(32'h8000_0000, 32'h9000_0000, 2'd3, 4'd2, 2'd1, 2'd0);
    refill(32'h8010_0000, 32'h9020_0000, 2'd1, 4'd3, 2'd2, 2'd1);
    inv_line = 1'b1; inv_va = 32'h800F_F123; tick(); inv_line = 1'b0;
    miss(32'h8000_0010, "R10 line removed");
    look(32'h8010_0010, 1'b1, 32'h9020_0010, 4'd3, 2'd2, 2'd1, "R10 neighbour kept");
    inv_line = 1'b1; inv_va = 32'h5000_0040; tick(); inv_line = 1'b0;
    look(32'h5000_0020, 1'b1, 32'h6000_0020, 4'd9, 2'd1, 2'd1, "R10 locked line kept");

    lockdown(6'd2, 6'd10, 1'b1);
    refill(32'hC000_0000, 32'hD000_0000, 2'd1, 4'd8, 2'd3, 2'd0);
    lockdown(6'd2, 6'd0, 1'b0);
    inv_all = 1'b1; tick(); inv_all = 1'b0;
    look(32'hC000_0044, 1'b1, 32'hD000_0044, 4'd8, 2'd3, 2'd0, "R8 pinned above base");

    refill(32'hA000_0000, 32'hB000_0000, 2'd1, 4'd1, 2'd1, 2'd1);
    inv_line = 1'b1; inv_va = 32'hA000_0000;
    miss(32'hA000_0004, "R11 line then lookup");
    inv_line = 1'b0;
    refill(32'hA001_0000, 32'hB001_0000, 2'd1, 4'd1, 2'd1, 2'd1);
    inv_all = 1'b1;
    miss(32'hA001_0004, "R11 flush then lookup");
    inv_all = 1'b0;
    look(32'h5000_1000, 1'b1, 32'h6000_1000, 4'd9, 2'd1, 2'd1, "R11 locked after flush");

    repeat (3) tick();
    chk(sb_q.size() == 0, "R1 all responses seen", 32'(sb_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule